// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block turns the two sampled USB data lines into received packet bytes. It runs from a clock that is a fixed multiple of the bit rate, which is 1.5 Mbit/s in low-speed operation. It decodes the differential line state, finds the centre of each bit cell, undoes the NRZI coding and drops stuffed bits. Each byte it assembles is delivered on a one-cycle strobe. A sync field opens a packet and is reported as a start strobe. A single-ended-zero followed by idle closes the packet.

Low-speed hosts keep a device awake by sending a bare end-of-packet with no packet around it. The block raises a sticky flag on every end-of-packet it sees, including these bare ones. The flag drops when the next packet starts, or when the line has sat in idle for seven bit times. Because of that second way of clearing, every keep-alive in a series shows up as a fresh rising edge of the flag. A single speed-select input swaps the J/K polarity, so the same logic also decodes full-speed line signalling.

Top module: `usb_ls_rx`

## Requirements
- R1: With `fs_mode` low, D- high with D+ low is J and the opposite pair is K. With `fs_mode` high, the two mappings are exchanged. Both lines low is a single-ended zero (SE0).
- R2: Each bit cell with the same line state as the cell before it decodes as 1. Each cell that changes state decodes as 0.
- R3: While no packet is open, the bit pattern K J K J K J K K, coming after idle J, is a sync field. Read least-significant bit first it forms the byte 0x80. It gives a one-cycle `pkt_start` and is not delivered as a data byte.
- R4: Data bits are packed least-significant bit first. Every eighth data bit gives a one-cycle `byte_valid`, with the byte on `rx_byte` in that same cycle.
- R5: A 0 that follows six consecutive decoded 1s is a stuffed bit. It is removed and does not enter any byte. The final 1 of the sync field counts toward that run of six.
- R6: If the bit after six consecutive 1s is a 1, the block gives a one-cycle `stuff_err` and abandons the packet. No further bytes and no `pkt_end` follow for that packet.
- R7: At least two bit times of SE0 followed by a J is an end-of-packet. If a packet is open, it gives a one-cycle `pkt_end`. Any partly assembled byte is discarded.
- R8: `eop_flag` is set by every end-of-packet. This includes a bare keep-alive end-of-packet while no packet is open, which does not give `pkt_end`.
- R9: `eop_flag` is cleared in the same cycle that `pkt_start` is given.
- R10: `eop_flag` is cleared once seven consecutive bit cells have been sampled as J. The J that ends the end-of-packet counts as the first of them.
- R11: Each bit cell lasts `OVERSAMPLE` clocks. The sampling phase restarts on every line transition, so a cell stretched by one clock is still sampled once.
- R12: While reset is asserted, `byte_valid`, `pkt_start`, `pkt_end`, `stuff_err`, `eop_flag` and `rx_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OVERSAMPLE` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_mode | input | 1 | Speed select: 1 swaps the J/K polarity to full-speed |
| dp | input | 1 | Sampled D+ line |
| dm | input | 1 | Sampled D- line |
| rx_byte | output | 8 | Received data byte |
| byte_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| pkt_start | output | 1 | One-cycle strobe: sync field found |
| pkt_end | output | 1 | One-cycle strobe: end of an open packet |
| stuff_err | output | 1 | One-cycle strobe: bit-stuffing violation, packet abandoned |
| eop_flag | output | 1 | Sticky end-of-packet / keep-alive flag |

## Verification
A sampling phase that drifts or fails to resynchronise shows up one bit cell later. The result is an extra or missing decoded bit, so the bytes of the current packet come out shifted or with wrong values. A stuffing counter that is off by one corrupts the first byte that contains a run of six 1s, or gives a spurious `stuff_err` in the same cell. A wrong packet state or a wrong idle-run count shows within a single bit time at `pkt_end` or `eop_flag`. These are sampled one cell after the end-of-packet J and at the seventh idle J.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  // Decoded differential line state
  typedef enum logic [1:0] {
    LN_SE0 = 2'd0,
    LN_J   = 2'd1,
    LN_K   = 2'd2,
    LN_SE1 = 2'd3
  } line_t;

  // Packet framing state
  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_DATA = 1'b1
  } rx_state_t;

endpackage

// File: rtl/usbrx_line.sv
// Line-state decoding and bit-centre sampling with phase resync on transitions.
module usbrx_line
  import usbrx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fs_mode,
  input  logic  dp,
  input  logic  dm,
  output line_t line_q,
  output logic  bit_stb
);

  localparam int unsigned CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] PH_MID  = CW'(OVERSAMPLE / 2);
  localparam logic [CW-1:0] PH_LAST = CW'(OVERSAMPLE - 1);

  line_t         line_d;
  line_t         line_prev;
  logic [CW-1:0] ph_q;
  logic [CW-1:0] ph_d;
  logic          edge_seen;

  // Polarity of J/K depends on the speed select
  always_comb begin
    unique case ({dp, dm})
      2'b00:   line_d = LN_SE0;
      2'b11:   line_d = LN_SE1;
      2'b10:   line_d = fs_mode ? LN_J : LN_K;
      default: line_d = fs_mode ? LN_K : LN_J;
    endcase
  end

  assign edge_seen = (line_q != line_prev);

  always_comb begin
    if (edge_seen)             ph_d = '0;
    else if (ph_q == PH_LAST)  ph_d = '0;
    else                       ph_d = ph_q + CW'(1);
  end

  assign bit_stb = (ph_q == PH_MID) && !edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= LN_J;
      line_prev <= LN_J;
      ph_q      <= '0;
    end else begin
      line_q    <= line_d;
      line_prev <= line_q;
      ph_q      <= ph_d;
    end
  end

endmodule

// File: rtl/usbrx_nrzi.sv
// NRZI decode plus SE0 run tracking; outputs are valid in the strobe cycle.
module usbrx_nrzi
  import usbrx_pkg::*;
#(
  parameter int unsigned SE0_MIN = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_stb,
  input  line_t line_q,
  output logic  bit_vld,
  output logic  bit_val,
  output logic  eop_evt,
  output logic  idle_j
);

  localparam int unsigned SW = $clog2(SE0_MIN + 1);
  localparam logic [SW-1:0] SE0_SAT = SW'(SE0_MIN);

  line_t         last_q;
  line_t         last_d;
  logic [SW-1:0] se0_q;
  logic [SW-1:0] se0_d;

  always_comb begin
    last_d  = last_q;
    se0_d   = se0_q;
    bit_vld = 1'b0;
    bit_val = 1'b0;
    eop_evt = 1'b0;
    idle_j  = 1'b0;
    if (bit_stb) begin
      if (line_q == LN_SE0 || line_q == LN_SE1) begin
        se0_d = (se0_q == SE0_SAT) ? se0_q : se0_q + SW'(1);
      end else begin
        idle_j = (line_q == LN_J);
        if (se0_q == SE0_SAT && line_q == LN_J) begin
          eop_evt = 1'b1;
        end else if (se0_q == '0) begin
          bit_vld = 1'b1;
          bit_val = (line_q == last_q);
        end
        last_d = line_q;
        se0_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LN_J;
      se0_q  <= '0;
    end else if (bit_stb) begin
      last_q <= last_d;
      se0_q  <= se0_d;
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
// Packet framing, unstuffing, byte assembly and keep-alive flag.
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 4,
  parameter int unsigned STUFF_RUN  = 6,
  parameter int unsigned IDLE_CLEAR = 7,
  parameter int unsigned SE0_MIN    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_mode,
  input  logic       dp,
  input  logic       dm,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       pkt_start,
  output logic       pkt_end,
  output logic       stuff_err,
  output logic       eop_flag
);

  localparam int unsigned OW = $clog2(STUFF_RUN + 1);
  localparam int unsigned JW = $clog2(IDLE_CLEAR + 1);
  localparam logic [OW-1:0] ONES_MAX = OW'(STUFF_RUN);
  localparam logic [JW-1:0] JRUN_MAX = JW'(IDLE_CLEAR);
  localparam logic [7:0]    SYNC_BYTE = 8'h80;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  line_t line_q;
  logic  bit_stb, bit_vld, bit_val, eop_evt, idle_j;

  usbrx_line #(.OVERSAMPLE(OVERSAMPLE)) u_line (
    .clk(clk), .rst_n(rst_i), .fs_mode(fs_mode), .dp(dp), .dm(dm),
    .line_q(line_q), .bit_stb(bit_stb)
  );

  usbrx_nrzi #(.SE0_MIN(SE0_MIN)) u_nrzi (
    .clk(clk), .rst_n(rst_i), .bit_stb(bit_stb), .line_q(line_q),
    .bit_vld(bit_vld), .bit_val(bit_val), .eop_evt(eop_evt), .idle_j(idle_j)
  );

  rx_state_t     state_q, state_d;
  logic [7:0]    sr_q, sr_d, byte_q, byte_d, shifted;
  logic [2:0]    bcnt_q, bcnt_d;
  logic [OW-1:0] ones_q, ones_d;
  logic [JW-1:0] jrun_q, jrun_d;
  logic          flag_q, flag_d;
  logic          bv_d, ps_d, pe_d, se_d;
  logic          bv_q, ps_q, pe_q, se_q;

  assign shifted = {bit_val, sr_q[7:1]};

  always_comb begin
    state_d = state_q;
    sr_d    = sr_q;
    byte_d  = byte_q;
    bcnt_d  = bcnt_q;
    ones_d  = ones_q;
    jrun_d  = jrun_q;
    flag_d  = flag_q;
    bv_d    = 1'b0;
    ps_d    = 1'b0;
    pe_d    = 1'b0;
    se_d    = 1'b0;

    if (idle_j)       jrun_d = (jrun_q == JRUN_MAX) ? jrun_q : jrun_q + JW'(1);
    else if (bit_stb) jrun_d = '0;

    if (idle_j && jrun_q == JRUN_MAX - JW'(1)) flag_d = 1'b0;

    if (eop_evt) begin
      flag_d  = 1'b1;
      pe_d    = (state_q == RX_DATA);
      state_d = RX_HUNT;
      sr_d    = 8'hFF;
    end else if (bit_vld) begin
      if (state_q == RX_HUNT) begin
        sr_d = shifted;
        if (shifted == SYNC_BYTE) begin
          state_d = RX_DATA;
          ps_d    = 1'b1;
          flag_d  = 1'b0;
          bcnt_d  = 3'd0;
          ones_d  = OW'(1);
        end
      end else if (ones_q == ONES_MAX) begin
        ones_d = '0;
        if (bit_val) begin
          se_d    = 1'b1;
          state_d = RX_HUNT;
          sr_d    = 8'hFF;
        end
      end else begin
        ones_d = bit_val ? ones_q + OW'(1) : '0;
        sr_d   = shifted;
        bcnt_d = bcnt_q + 3'd1;
        if (bcnt_q == 3'd7) begin
          byte_d = shifted;
          bv_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= RX_HUNT;
      sr_q    <= 8'hFF;
      byte_q  <= 8'h00;
      bcnt_q  <= 3'd0;
      ones_q  <= '0;
      jrun_q  <= '0;
      flag_q  <= 1'b0;
      bv_q    <= 1'b0;
      ps_q    <= 1'b0;
      pe_q    <= 1'b0;
      se_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      byte_q  <= byte_d;
      bcnt_q  <= bcnt_d;
      ones_q  <= ones_d;
      jrun_q  <= jrun_d;
      flag_q  <= flag_d;
      bv_q    <= bv_d;
      ps_q    <= ps_d;
      pe_q    <= pe_d;
      se_q    <= se_d;
    end
  end

  assign rx_byte    = byte_q;
  assign byte_valid = bv_q;
  assign pkt_start  = ps_q;
  assign pkt_end    = pe_q;
  assign stuff_err  = se_q;
  assign eop_flag   = flag_q;

endmodule

// File: rtl/usb_ls_rx_chk.sv
// Port-level temporal checks, attached to the receiver by bind.
module usb_ls_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic pkt_start,
  input logic pkt_end,
  input logic stuff_err,
  input logic eop_flag
);

  assert_sop_not_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> !byte_valid);

  assert_byte_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (!byte_valid && !pkt_end));

  assert_end_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> eop_flag);

  assert_sop_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> !eop_flag);

  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start);

endmodule

bind usb_ls_rx usb_ls_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
  .pkt_end(pkt_end), .stuff_err(stuff_err), .eop_flag(eop_flag)
);

// File: tb/usb_ls_rx_test.sv
module usb_ls_rx_test;

  localparam int OS = 4;

  logic       clk;
  logic       rst_n;
  logic       fs_mode;
  logic       dp, dm;
  logic [7:0] rx_byte;
  logic       byte_valid, pkt_start, pkt_end, stuff_err, eop_flag;

  usb_ls_rx #(.OVERSAMPLE(OS)) uut (
    .clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .dp(dp), .dm(dm),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .pkt_start(pkt_start),
    .pkt_end(pkt_end), .stuff_err(stuff_err), .eop_flag(eop_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Output monitor
  int         got_n  = 0;
  logic [7:0] got [0:63];
  int         starts = 0, ends = 0, errs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (got_n < 64) got[got_n] = rx_byte;
        got_n++;
      end
      if (pkt_start) starts++;
      if (pkt_end)   ends++;
      if (stuff_err) errs++;
    end
  end

  // Line driver state
  bit         cur_j;
  int         ones_tx;
  int         cell_no   = 0;
  int         stretch_at = -1;
  logic [7:0] txb [0:63];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 = SE0, 1 = J, 2 = K  (R1 polarity from fs_mode)
  task automatic drive_cell(input int kind);
    case (kind)
      0:       {dp, dm} = 2'b00;
      1:       {dp, dm} = fs_mode ? 2'b10 : 2'b01;
      default: {dp, dm} = fs_mode ? 2'b01 : 2'b10;
    endcase
    repeat (OS) @(negedge clk);
    if (cell_no == stretch_at) @(negedge clk);   // R11 one-clock stretch
    cell_no++;
  endtask

  task automatic raw_bit(input bit b);
    if (!b) cur_j = !cur_j;
    drive_cell(cur_j ? 1 : 2);
  endtask

  task automatic send_bit(input bit b);
    raw_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 6) begin
        raw_bit(1'b0);
        ones_tx = 0;
      end
    end else begin
      ones_tx = 0;
    end
  endtask

  task automatic send_sync();
    cur_j   = 1'b1;
    ones_tx = 0;
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    send_bit(1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_cell(1);
    cur_j = 1'b1;
  endtask

  // Full packet with self-check of framing, flag and bytes
  task automatic run_packet(input int n, input int extra_bits, input string tag);
    int s0, e0;
    s0 = starts;
    e0 = ends;
    got_n = 0;
    send_sync();
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) send_bit(txb[k][b]);
    for (int b = 0; b < extra_bits; b++) send_bit(b[0]);
    drive_cell(0);
    check(starts == s0 + 1, {tag, " R3 pkt_start count"}, starts, s0 + 1);
    check(eop_flag == 1'b0, {tag, " R9 flag cleared by SOP"}, eop_flag, 0);
    drive_cell(0);
    drive_cell(1);
    cur_j = 1'b1;
    idle(1);
    check(ends == e0 + 1, {tag, " R7 pkt_end count"}, ends, e0 + 1);
    check(eop_flag == 1'b1, {tag, " R8 flag set by EOP"}, eop_flag, 1);
    check(got_n == n, {tag, " R4 byte count"}, got_n, n);
    for (int k = 0; k < n && k < got_n; k++)
      check(got[k] == txb[k], {tag, " R2 R4 R5 byte value"}, got[k], txb[k]);
    idle(2);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n, e0, x0;
    void'($urandom(32'd20180602));
    rst_n   = 1'b0;
    fs_mode = 1'b0;
    {dp, dm} = 2'b01;
    repeat (3) @(negedge clk);
    // R12 reset state
    check({rx_byte, byte_valid, pkt_start, pkt_end, stuff_err, eop_flag} == '0,
          "R12 outputs zero in reset",
          {rx_byte, byte_valid, pkt_start, pkt_end, stuff_err, eop_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_j = 1'b1;
    idle(4);

    // R8 R10: bare keep-alive EOP and idle-run clear
    e0 = ends;
    drive_cell(0); drive_cell(0); drive_cell(1);
    idle(6);   // 7 J cells driven: 6 processed at this point
    check(eop_flag == 1'b1, "R8 keep-alive sets flag", eop_flag, 1);
    check(ends == e0, "R8 no pkt_end without packet", ends, e0);
    idle(1);   // seventh J now processed
    check(eop_flag == 1'b0, "R10 flag cleared after 7 idle J", eop_flag, 0);
    // Repeated keep-alive seen again
    drive_cell(0); drive_cell(0); drive_cell(1); idle(1);
    check(eop_flag == 1'b1, "R8 second keep-alive sets flag", eop_flag, 1);
    idle(2);

    // Directed: empty packet, 0xFF bytes (stuffing), mixed pattern
    run_packet(0, 0, "empty");
    txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'h3F; txb[3] = 8'hFC;
    run_packet(4, 0, "stuff R5");
    txb[0] = 8'hD2; txb[1] = 8'h00; txb[2] = 8'h7E;
    run_packet(3, 0, "mixed");
    // R7 partial byte discarded
    txb[0] = 8'hA5;
    run_packet(1, 3, "partial R7");

    // R6 stuff violation: six raw 1s after the sync
    x0 = errs; e0 = ends; got_n = 0;
    send_sync();
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    drive_cell(0);
    check(errs == x0 + 1, "R6 stuff_err pulse", errs, x0 + 1);
    drive_cell(0); drive_cell(1); cur_j = 1'b1; idle(1);
    check(ends == e0, "R6 no pkt_end after abort", ends, e0);
    check(got_n == 0, "R6 no bytes after abort", got_n, 0);
    check(eop_flag == 1'b1, "R8 EOP after abort sets flag", eop_flag, 1);
    idle(2);

    // Random packets, some with a stretched cell (R11), both speeds (R1)
    for (int p = 0; p < 24; p++) begin
      if (p == 12) begin
        fs_mode = 1'b1;
        {dp, dm} = 2'b10;
        idle(3);
      end
      n = $urandom_range(0, 10);
      for (int k = 0; k < n; k++)
        txb[k] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
      stretch_at = cell_no + $urandom_range(4, 40);
      run_packet(n, 0, fs_mode ? "random fs R1 R11" : "random ls R11");
    end
    stretch_at = -1;

    finish_up();
  end

endmodule